// File: doc/BRIEF.md
# DMA Channel Event Flag and Interrupt Unit

This block keeps the sticky event flags of a group of DMA channels (seven by default) and turns them into one interrupt line per channel. For each channel the transfer engine raises single-cycle strobes when a transfer error occurs, when half of the programmed items have moved, and when the last item has moved. Each strobe sets its own flag. A fourth per-channel flag, the summary flag, is set by any of the three events.

Software reads every flag at once as a packed status word. Each channel owns a 4-bit field in that word. Software clears flags by presenting a clear word for one cycle, with a 1 in every bit position to be cleared. Three enables per channel decide which of the error, half and complete flags drive that channel's interrupt line. The flags themselves are recorded whatever the enables say.

Top module: `dma_irq_flags`

## Requirements
- R1: After reset every flag is 0, the status word reads 0x00000000 and every interrupt line is low.
- R2: A strobe on `evt_err`, `evt_half` or `evt_done` for channel c sets the matching flag at the next clock edge, whatever the enables hold. It is visible on `status_word` one cycle after the strobe.
- R3: Any event strobe on channel c also sets that channel's summary flag at the same edge.
- R4: A 1 in the clear-word bit of a channel's error, half or complete flag clears only that flag at the next edge. The summary flag stays set.
- R5: A 0 in a clear-word bit has no effect. A 1 in a reserved clear-word bit (31:28 by default) has no effect. A 1 on a flag that is already 0 has no effect.
- R6: A 1 in a channel's summary clear bit clears all four flags of that channel at the next edge.
- R7: When an event strobe and a clear of the same flag arrive in the same cycle, the flag ends up set. This holds whether the clear is the flag's own bit or the summary bit.
- R8: `irq[c]` is high exactly when at least one of channel c's error, half or complete flags is set and its enable is 1. With the default combinational option it follows the flags and enables in the same cycle.
- R9: An interrupt line stays high for as long as its enabled flag is set. It drops only after software clears that flag.
- R10: Channel c (counting from 0) occupies bits 4c+3..4c of the status word and of the clear word. Bit 4c is the summary flag, 4c+1 is complete, 4c+2 is half and 4c+3 is error. Bits above the last channel field read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_err | input | NCH | Per-channel transfer error strobe |
| evt_half | input | NCH | Per-channel half-transfer strobe |
| evt_done | input | NCH | Per-channel transfer complete strobe |
| clr_word | input | STATUS_W | Write-one-to-clear word, held for one cycle per write |
| en_err | input | NCH | Per-channel error interrupt enable |
| en_half | input | NCH | Per-channel half-transfer interrupt enable |
| en_done | input | NCH | Per-channel complete interrupt enable |
| status_word | output | STATUS_W | Packed flag readout |
| irq | output | NCH | Per-channel interrupt line |

## Verification
The bound checker looks at every channel on every cycle. It checks that each event strobe is followed by its flag and by the summary flag, even when a clear arrives at the same time. It checks that a summary clear with no event empties the channel field, and that a cycle with neither events nor clear bits leaves the status word unchanged. It also checks that the interrupt lines agree with the readable flags gated by the enables, and that the reserved bits stay at zero.

Some behaviours need the bench's scenarios. One is that clearing a single flag leaves the summary flag set. Another is that reserved clear bits are ignored. A third is that a line stays high across idle cycles until software clears the flag. The bench also checks the exact bit placement of each channel's field, using accumulated multi-cycle histories.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   // Width of one channel field in the status and clear words
   localparam int unsigned FIELD_W = 4;
   // Bit positions inside a channel field; software decodes these
   localparam int unsigned BIT_SUM  = 0;
   localparam int unsigned BIT_DONE = 1;
   localparam int unsigned BIT_HALF = 2;
   localparam int unsigned BIT_ERR  = 3;

   typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
   import dma_irq_pkg::*;
#(
   parameter bit REG_IRQ = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   set_err,
   input  logic   set_half,
   input  logic   set_done,
   input  field_t clr_field,
   input  logic   en_err,
   input  logic   en_half,
   input  logic   en_done,
   output field_t field,
   output logic   irq
);
   logic f_sum, f_done, f_half, f_err;
   logic clr_all;
   logic any_set;
   logic irq_raw;

   assign clr_all = clr_field[BIT_SUM];
   assign any_set = set_err | set_half | set_done;

   // Set dominates clear so no event is lost (R7)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_sum  <= 1'b0;
         f_done <= 1'b0;
         f_half <= 1'b0;
         f_err  <= 1'b0;
      end else begin
         f_sum  <= any_set  | (f_sum  & ~clr_all);
         f_done <= set_done | (f_done & ~(clr_field[BIT_DONE] | clr_all));
         f_half <= set_half | (f_half & ~(clr_field[BIT_HALF] | clr_all));
         f_err  <= set_err  | (f_err  & ~(clr_field[BIT_ERR]  | clr_all));
      end
   end

   always_comb begin
      field           = '0;
      field[BIT_SUM]  = f_sum;
      field[BIT_DONE] = f_done;
      field[BIT_HALF] = f_half;
      field[BIT_ERR]  = f_err;
   end

   assign irq_raw = (f_err & en_err) | (f_half & en_half) | (f_done & en_done);

   generate
      if (REG_IRQ) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate
endmodule

// File: rtl/dma_irq_pack.sv
module dma_irq_pack
   import dma_irq_pkg::*;
#(
   parameter int unsigned NCH      = 7,
   parameter int unsigned STATUS_W = 32
) (
   input  logic [NCH*FIELD_W-1:0] fields,
   output logic [STATUS_W-1:0]    status_word
);
   localparam int unsigned USED_W = NCH * FIELD_W;
   localparam int unsigned PAD_W  = STATUS_W - USED_W;

   generate
      if (PAD_W > 0) begin : g_pad
         assign status_word = {{PAD_W{1'b0}}, fields};
      end else begin : g_full
         assign status_word = fields;
      end
   endgenerate
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
   import dma_irq_pkg::*;
#(
   parameter int unsigned NCH      = 7,
   parameter int unsigned STATUS_W = 32,
   parameter bit          REG_IRQ  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NCH-1:0]      evt_err,
   input  logic [NCH-1:0]      evt_half,
   input  logic [NCH-1:0]      evt_done,
   input  logic [STATUS_W-1:0] clr_word,
   input  logic [NCH-1:0]      en_err,
   input  logic [NCH-1:0]      en_half,
   input  logic [NCH-1:0]      en_done,
   output logic [STATUS_W-1:0] status_word,
   output logic [NCH-1:0]      irq
);
   localparam int unsigned USED_W = NCH * FIELD_W;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("dma_irq_flags: NCH must be at least 1");
      end
      if (USED_W > STATUS_W) begin : g_bad_width
         $error("dma_irq_flags: channel fields exceed STATUS_W");
      end
   endgenerate

   logic [USED_W-1:0] fields;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_chan
         dma_irq_chan #(
            .REG_IRQ (REG_IRQ)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_err   (evt_err[c]),
            .set_half  (evt_half[c]),
            .set_done  (evt_done[c]),
            .clr_field (clr_word[c*FIELD_W +: FIELD_W]),
            .en_err    (en_err[c]),
            .en_half   (en_half[c]),
            .en_done   (en_done[c]),
            .field     (fields[c*FIELD_W +: FIELD_W]),
            .irq       (irq[c])
         );
      end
   endgenerate

   dma_irq_pack #(
      .NCH      (NCH),
      .STATUS_W (STATUS_W)
   ) u_pack (
      .fields      (fields),
      .status_word (status_word)
   );
endmodule

// File: rtl/dma_irq_flags_chk.sv
module dma_irq_flags_chk
   import dma_irq_pkg::*;
#(
   parameter int unsigned NCH      = 7,
   parameter int unsigned STATUS_W = 32,
   parameter bit          REG_IRQ  = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NCH-1:0]      evt_err,
   input logic [NCH-1:0]      evt_half,
   input logic [NCH-1:0]      evt_done,
   input logic [STATUS_W-1:0] clr_word,
   input logic [NCH-1:0]      en_err,
   input logic [NCH-1:0]      en_half,
   input logic [NCH-1:0]      en_done,
   input logic [STATUS_W-1:0] status_word,
   input logic [NCH-1:0]      irq
);
   localparam int unsigned USED_W = NCH * FIELD_W;

   // R5
   quiet_cycle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_err == '0 && evt_half == '0 && evt_done == '0 && clr_word == '0)
      |=> $stable(status_word));

   generate
      if (USED_W < STATUS_W) begin : g_rsv
         // R10
         reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status_word[STATUS_W-1:USED_W] == '0);
      end

      for (genvar c = 0; c < NCH; c++) begin : g_ch
         localparam int unsigned B = c * FIELD_W;

         // R2
         err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_err[c] |=> status_word[B+BIT_ERR]);
         // R2
         half_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_half[c] |=> status_word[B+BIT_HALF]);
         // R7
         done_sets_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_done[c] |=> status_word[B+BIT_DONE]);
         // R3
         sum_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_err[c] || evt_half[c] || evt_done[c]) |=> status_word[B+BIT_SUM]);
         // R6
         sum_clr_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_word[B+BIT_SUM] && !evt_err[c] && !evt_half[c] && !evt_done[c])
            |=> status_word[B +: FIELD_W] == '0);

         if (!REG_IRQ) begin : g_comb
            // R8
            irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
               irq[c] == ((status_word[B+BIT_ERR]  && en_err[c]) ||
                          (status_word[B+BIT_HALF] && en_half[c]) ||
                          (status_word[B+BIT_DONE] && en_done[c])));
         end else begin : g_reg
            // R8
            irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
               $past(rst_n) |-> irq[c] == $past(
                         (status_word[B+BIT_ERR]  && en_err[c]) ||
                         (status_word[B+BIT_HALF] && en_half[c]) ||
                         (status_word[B+BIT_DONE] && en_done[c])));
         end
      end
   endgenerate
endmodule

bind dma_irq_flags dma_irq_flags_chk #(
   .NCH      (NCH),
   .STATUS_W (STATUS_W),
   .REG_IRQ  (REG_IRQ)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_err     (evt_err),
   .evt_half    (evt_half),
   .evt_done    (evt_done),
   .clr_word    (clr_word),
   .en_err      (en_err),
   .en_half     (en_half),
   .en_done     (en_done),
   .status_word (status_word),
   .irq         (irq)
);

// File: tb/dma_irq_flags_tb.sv
module dma_irq_flags_tb;
   localparam int unsigned NCH = 7;
   localparam int unsigned SW  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NCH-1:0] evt_err = '0, evt_half = '0, evt_done = '0;
   logic [SW-1:0]  clr_word = '0;
   logic [NCH-1:0] en_err = '0, en_half = '0, en_done = '0;
   logic [SW-1:0]  status_word;
   logic [NCH-1:0] irq;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dma_irq_flags #(.NCH(NCH), .STATUS_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .evt_err(evt_err), .evt_half(evt_half), .evt_done(evt_done),
      .clr_word(clr_word),
      .en_err(en_err), .en_half(en_half), .en_done(en_done),
      .status_word(status_word), .irq(irq)
   );

   typedef struct packed {
      logic [6:0]  err;
      logic [6:0]  half;
      logic [6:0]  done;
      logic [31:0] clr;
      logic [6:0]  ee;
      logic [6:0]  eh;
      logic [6:0]  ed;
      logic [31:0] exp_st;
      logic [6:0]  exp_irq;
   } vec_t;

   // Field of channel c: bit 4c summary, 4c+1 complete, 4c+2 half, 4c+3 error
   localparam int NVEC = 8;
   localparam vec_t TBL [0:NVEC-1] = '{
      // R2 R3: complete on ch0, no enables
      '{7'h00, 7'h00, 7'h01, 32'h0,        7'h00, 7'h00, 7'h00, 32'h00000003, 7'h00},
      // R2 R3 R8: half ch2, error ch6, complete enabled on ch0
      '{7'h40, 7'h04, 7'h00, 32'h0,        7'h00, 7'h00, 7'h01, 32'h09000503, 7'h01},
      // R4 R8: clear complete of ch0, summary stays
      '{7'h00, 7'h00, 7'h00, 32'h00000002, 7'h00, 7'h04, 7'h01, 32'h09000501, 7'h04},
      // R5: reserved clear bits only
      '{7'h00, 7'h00, 7'h00, 32'hF0000000, 7'h00, 7'h04, 7'h01, 32'h09000501, 7'h04},
      // R6: summary clear of ch2
      '{7'h00, 7'h00, 7'h00, 32'h00000100, 7'h00, 7'h04, 7'h01, 32'h09000001, 7'h00},
      // R7: error set and error clear on ch6 together
      '{7'h40, 7'h00, 7'h00, 32'h08000000, 7'h40, 7'h04, 7'h01, 32'h09000001, 7'h40},
      // R7: complete set and summary clear on ch3 together
      '{7'h00, 7'h00, 7'h08, 32'h00001000, 7'h40, 7'h04, 7'h01, 32'h09003001, 7'h40},
      // R6: summary clears on ch0, ch3, ch6
      '{7'h00, 7'h00, 7'h00, 32'h01001001, 7'h40, 7'h04, 7'h01, 32'h00000000, 7'h00}
   };

   task automatic chk_st(input string req, input logic [31:0] exp);
      total++;
      if (status_word !== exp) begin
         bad++;
         $display("FAIL %s status actual=%08h expected=%08h", req, status_word, exp);
      end
   endtask

   task automatic chk_irq(input string req, input logic [6:0] exp);
      total++;
      if (irq !== exp) begin
         bad++;
         $display("FAIL %s irq actual=%02h expected=%02h", req, irq, exp);
      end
   endtask

   // One cycle of strobes applied at a falling edge, sampled at the next falling edge
   task automatic step(input logic [6:0] e, input logic [6:0] h, input logic [6:0] d,
                       input logic [31:0] c);
      evt_err = e; evt_half = h; evt_done = d; clr_word = c;
      @(negedge clk);
      evt_err = '0; evt_half = '0; evt_done = '0; clr_word = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_st("R1", 32'h0);
      chk_irq("R1", 7'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk_st("R1", 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         en_err = TBL[i].ee; en_half = TBL[i].eh; en_done = TBL[i].ed;
         step(TBL[i].err, TBL[i].half, TBL[i].done, TBL[i].clr);
         chk_st($sformatf("R2-vec%0d", i), TBL[i].exp_st);
         chk_irq($sformatf("R8-vec%0d", i), TBL[i].exp_irq);
      end

      // R10: every event on every channel lands in its own field, pad stays zero
      en_err = '0; en_half = '0; en_done = '0;
      step('1, '1, '1, 32'h0);
      chk_st("R10", 32'h0FFFFFFF);
      step('0, '0, '0, 32'hFFFFFFFF);
      chk_st("R6", 32'h0);

      // R9: line held across idle cycles until clear
      en_done = 7'h02;
      step(7'h00, 7'h00, 7'h02, 32'h0);
      repeat (5) @(negedge clk);
      chk_irq("R9", 7'h02);
      chk_st("R9", 32'h00000030);
      // R8: dropping the enable drops the line, flag kept
      en_done = 7'h00;
      #1;
      chk_irq("R8", 7'h00);
      en_done = 7'h02;
      step(7'h00, 7'h00, 7'h00, 32'h00000020);
      chk_irq("R9", 7'h00);
      chk_st("R4", 32'h00000010);

      // R5: clearing an already-zero flag on ch4 leaves ch1 summary alone
      step(7'h00, 7'h00, 7'h00, 32'h000F0000);
      chk_st("R5", 32'h00000010);

      // R1: reset mid-run wipes flags
      en_half = 7'h10;
      step(7'h00, 7'h10, 7'h00, 32'h0);
      chk_irq("R8", 7'h10);
      rst_n = 1'b0;
      @(negedge clk);
      chk_st("R1", 32'h0);
      chk_irq("R1", 7'h00);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule